// File: doc/BRIEF.md
# Dual-view GPIO register bank

The block holds the output enable and output data state of up to 128 digital I/O pins and samples their input levels, all reached through byte-wide register ports. Two address maps alias the same state. In the per-pin view, each pin owns one byte at an address equal to its pin index. That byte holds the pin's enable bit, its data bit and its synchronised input level. In the banked view, eight consecutive pins share one byte, with separate bank groups for input, output data and output enable. A pin's bank is its index divided by eight, and its bit in that bank is the index modulo eight.

Software that changes one pin at a time uses the per-pin view. A controller that must move many pins in one cycle uses the banked view. Either view can read back what the other wrote, because both views reach the same flops. The block has `NPORTS` register ports (two by default). Each port has its own address, write data, write strobe and read data. Reads are combinational from the port's address. A write takes effect on the clock edge where its strobe is high. The ports carry register accesses, not streams, so they are plain strobes with no back-pressure. A write is always accepted in the cycle it is presented.

Top module: `gpio_dualview`

## Requirements
- R1: After reset, every pin's output enable and output data are 0, so `pin_oe` and `pin_out` are all zero and every pin is an input.
- R2: A read at address i (0 ≤ i < NPINS) returns bit 0 = output enable of pin i, bit 1 = output data of pin i, bit 2 = synchronised input of pin i, and bits 7:3 = 0.
- R3: A change on `pin_in` becomes visible in reads two rising clock edges after it is sampled: first after the second edge, and not after the first.
- R4: A write at address i < NPINS loads output enable from write bit 0 and output data from write bit 1, both on the same edge. It changes no other pin. Writing 0x01 makes the pin a low output.
- R5: Banked reads return eight pins per byte, with bit k of bank b mapping to pin 8b+k. Input banks are at 0x0100+b, output data banks at 0x0110+b and output enable banks at 0x0120+b.
- R6: A write at 0x0110+b loads the output data of pins 8b..8b+7 from the write byte. A write at 0x0120+b loads their output enables. The result reads back in the per-pin view.
- R7: Writes to bit 2 or bits 7:3 of a per-pin register, to the input banks 0x0100–0x010F, or to any unmapped address change no output enable or output data.
- R8: Reads of unmapped addresses (for example 0x0080, 0x0130, 0x01FF) return 0.
- R9: When a banked write and a per-pin write reach the same pin on the same edge, the field the banked write covers takes the banked value. The other field takes the per-pin value.
- R10: When two ports write the same field of the same pin through the same view on one edge, the higher-numbered port's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | NPORTS x ADDR_W | Register address, one per port |
| bus_wdata | input | NPORTS x 8 | Write data, one per port |
| bus_we | input | NPORTS | Write strobe, one per port |
| bus_rdata | output | NPORTS x 8 | Read data for the port's current address |
| pin_out | output | NPINS | Output data per pin |
| pin_oe | output | NPINS | Output enable per pin |
| pin_in | input | NPINS | Raw pin input levels |

## Verification
The assertions check the following on every cycle:
- Reserved per-pin bits and unmapped addresses read as zero.
- The input path carries exactly two edges of latency.
- A cycle with no decoded write leaves all output state untouched.
- A lone per-pin write to pin 0 loads both fields.
- A banked data write wins over a same-cycle per-pin write to pin 0.

Only the bench's scenarios show the following:
- The full per-pin and banked address sweeps.
- Coherence between the two views after mixed writes.
- Port priority.
- The exact edge on which an input change first appears.

// File: rtl/gpio_db_pkg.sv
package gpio_db_pkg;
  localparam int DATA_W       = 8;
  localparam int BANK_IN_BASE = 'h0100;
  localparam int BANK_OD_BASE = 'h0110;
  localparam int BANK_OE_BASE = 'h0120;
  localparam int BANK_SPAN    = 16;
  localparam int PP_OE_BIT    = 0;
  localparam int PP_OD_BIT    = 1;
  localparam int PP_IN_BIT    = 2;
endpackage

// File: rtl/gpio_db_sync.sv
module gpio_db_sync #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_q
);
  logic [WIDTH-1:0] stage1;
  logic [1:0]       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      sync_q <= '0;
    end else begin
      stage1 <= raw_in;
      sync_q <= stage1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R3: exactly two edges from the pin to the readable input bit
  a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (sync_q == $past(raw_in, 2)));
endmodule

// File: rtl/gpio_db_state.sv
module gpio_db_state
  import gpio_db_pkg::*;
#(
  parameter int NPINS  = 128,
  parameter int NPORTS = 2,
  parameter int ADDR_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NPORTS-1:0][ADDR_W-1:0]       addr,
  input  logic [NPORTS-1:0][DATA_W-1:0]       wdata,
  input  logic [NPORTS-1:0]                   we,
  output logic [NPINS-1:0]                    oe_q,
  output logic [NPINS-1:0]                    od_q
);
  localparam int NBANK  = NPINS / 8;
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int PIN_W  = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [ADDR_W-1:0] PIN_END = ADDR_W'(NPINS);
  localparam logic [ADDR_W-1:0] OD_LO   = ADDR_W'(BANK_OD_BASE);
  localparam logic [ADDR_W-1:0] OD_HI   = ADDR_W'(BANK_OD_BASE + NBANK);
  localparam logic [ADDR_W-1:0] OE_LO   = ADDR_W'(BANK_OE_BASE);
  localparam logic [ADDR_W-1:0] OE_HI   = ADDR_W'(BANK_OE_BASE + NBANK);

  logic [NPORTS-1:0] pp_hit, bo_hit, be_hit;
  logic [NPINS-1:0]  oe_d, od_d;

  for (genvar p = 0; p < NPORTS; p++) begin : g_dec
    assign pp_hit[p] = we[p] && (addr[p] < PIN_END);
    assign bo_hit[p] = we[p] && (addr[p] >= OD_LO) && (addr[p] < OD_HI);
    assign be_hit[p] = we[p] && (addr[p] >= OE_LO) && (addr[p] < OE_HI);
  end

  // per-pin writes first, then banked writes so banked fields win (R9);
  // ascending port order so the higher port wins within a view (R10)
  always_comb begin
    oe_d = oe_q;
    od_d = od_q;
    for (int p = 0; p < NPORTS; p++) begin
      if (pp_hit[p]) begin
        oe_d[addr[p][PIN_W-1:0]] = wdata[p][PP_OE_BIT];
        od_d[addr[p][PIN_W-1:0]] = wdata[p][PP_OD_BIT];
      end
    end
    for (int p = 0; p < NPORTS; p++) begin
      for (int k = 0; k < 8; k++) begin
        if (bo_hit[p]) od_d[int'(addr[p][BANK_W-1:0]) * 8 + k] = wdata[p][k];
        if (be_hit[p]) oe_d[int'(addr[p][BANK_W-1:0]) * 8 + k] = wdata[p][k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= '0;
      od_q <= '0;
    end else begin
      oe_q <= oe_d;
      od_q <= od_d;
    end
  end

  // R7: no decoded write, no change of output state
  a_r7_no_stray_update: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pp_hit | bo_hit | be_hit)) |=> ($stable(oe_q) && $stable(od_q)));

  // R4: a lone per-pin write to pin 0 loads both fields on one edge
  a_r4_pin_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_hit[NPORTS-1] && addr[NPORTS-1] == '0 && !(|bo_hit) && !(|be_hit))
    |=> (oe_q[0] == $past(wdata[NPORTS-1][PP_OE_BIT]) &&
         od_q[0] == $past(wdata[NPORTS-1][PP_OD_BIT])));

  // R9: banked data write wins over a per-pin write on the same pin
  a_r9_bank_over_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_hit[0] && addr[0] == '0 && bo_hit[NPORTS-1] && addr[NPORTS-1] == OD_LO)
    |=> (od_q[0] == $past(wdata[NPORTS-1][0])));
endmodule

// File: rtl/gpio_db_rdmux.sv
module gpio_db_rdmux
  import gpio_db_pkg::*;
#(
  parameter int NPINS  = 128,
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  in_q,
  input  logic [NPINS-1:0]  od_q,
  input  logic [NPINS-1:0]  oe_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int NBANK  = NPINS / 8;
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int PIN_W  = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [ADDR_W-1:0] PIN_END = ADDR_W'(NPINS);
  localparam logic [ADDR_W-1:0] IN_LO   = ADDR_W'(BANK_IN_BASE);
  localparam logic [ADDR_W-1:0] IN_HI   = ADDR_W'(BANK_IN_BASE + NBANK);
  localparam logic [ADDR_W-1:0] OD_LO   = ADDR_W'(BANK_OD_BASE);
  localparam logic [ADDR_W-1:0] OD_HI   = ADDR_W'(BANK_OD_BASE + NBANK);
  localparam logic [ADDR_W-1:0] OE_LO   = ADDR_W'(BANK_OE_BASE);
  localparam logic [ADDR_W-1:0] OE_HI   = ADDR_W'(BANK_OE_BASE + NBANK);

  logic [PIN_W-1:0] pin;
  int               bsel;

  assign pin  = addr[PIN_W-1:0];
  assign bsel = int'(addr[BANK_W-1:0]) * 8;

  always_comb begin
    rdata = '0;
    if (addr < PIN_END) begin
      rdata[PP_OE_BIT] = oe_q[pin];
      rdata[PP_OD_BIT] = od_q[pin];
      rdata[PP_IN_BIT] = in_q[pin];
    end else if (addr >= IN_LO && addr < IN_HI) begin
      rdata = in_q[bsel +: 8];
    end else if (addr >= OD_LO && addr < OD_HI) begin
      rdata = od_q[bsel +: 8];
    end else if (addr >= OE_LO && addr < OE_HI) begin
      rdata = oe_q[bsel +: 8];
    end
  end
endmodule

// File: rtl/gpio_dualview.sv
module gpio_dualview
  import gpio_db_pkg::*;
#(
  parameter int NPINS  = 128,
  parameter int NPORTS = 2,
  parameter int ADDR_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORTS-1:0][ADDR_W-1:0] bus_addr,
  input  logic [NPORTS-1:0][DATA_W-1:0] bus_wdata,
  input  logic [NPORTS-1:0]             bus_we,
  output logic [NPORTS-1:0][DATA_W-1:0] bus_rdata,
  output logic [NPINS-1:0]              pin_out,
  output logic [NPINS-1:0]              pin_oe,
  input  logic [NPINS-1:0]              pin_in
);
  localparam logic [ADDR_W-1:0] PIN_END = ADDR_W'(NPINS);
  localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(BANK_OE_BASE + BANK_SPAN);

  logic [NPINS-1:0] in_sync;

  gpio_db_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_q(in_sync)
  );

  gpio_db_state #(.NPINS(NPINS), .NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_state (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .oe_q(pin_oe), .od_q(pin_out)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_rd
    gpio_db_rdmux #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_rdmux (
      .addr(bus_addr[p]), .in_q(in_sync), .od_q(pin_out), .oe_q(pin_oe),
      .rdata(bus_rdata[p])
    );

    // R2: reserved bits of the per-pin layout always read 0
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[p] < PIN_END) |-> (bus_rdata[p][7:3] == 5'd0));

    // R8: addresses past the last bank group read 0
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[p] >= MAP_END) |-> (bus_rdata[p] == 8'd0));
  end
endmodule

// File: tb/gpio_dualview_tb.sv
module gpio_dualview_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 128;
  localparam int NPT = 2;

  logic clk = 0, rst_n = 0;
  logic [NPT-1:0][15:0] addr = '0;
  logic [NPT-1:0][7:0]  wdata = '0;
  logic [NPT-1:0]       we = '0;
  logic [NPT-1:0][7:0]  rdata;
  logic [NP-1:0] pin_out, pin_oe, pin_in = '0;
  logic [NP-1:0] m_oe = '0, m_od = '0, m_in = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_dualview u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_in(pin_in)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic rd(int p, logic [15:0] a, output logic [7:0] v);
    @(negedge clk); addr[p] = a; #1; v = rdata[p];
  endtask

  task automatic wr(int p, logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr[p] = a; wdata[p] = d; we[p] = 1'b1;
    @(negedge clk); we[p] = 1'b0;
  endtask

  task automatic wr2(logic [15:0] a0, logic [7:0] d0, logic [15:0] a1, logic [7:0] d1);
    @(negedge clk); addr[0] = a0; wdata[0] = d0; addr[1] = a1; wdata[1] = d1; we = 2'b11;
    @(negedge clk); we = 2'b00;
  endtask

  function automatic logic [7:0] pp_exp(int i);
    return {5'b0, m_in[i], m_od[i], m_oe[i]};
  endfunction

  task automatic sweep_pins(string req);
    logic [7:0] v;
    for (int i = 0; i < NP; i++) begin
      rd(i % NPT, 16'(i), v);
      chk(req, 128'(v), 128'(pp_exp(i)));
    end
    chk(req, pin_oe, m_oe);
    chk(req, pin_out, m_od);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1", pin_oe, '0);
    chk("R1", pin_out, '0);
    sweep_pins("R1");

    // R4 + R7: per-pin writes with reserved and input bits set
    for (int i = 0; i < NP; i++) begin
      wr(i % NPT, 16'(i), 8'hFC | 8'((i * 3 + 1) % 4));
      m_oe[i] = ((i * 3 + 1) % 4) & 1;
      m_od[i] = (((i * 3 + 1) % 4) >> 1) & 1;
      chk("R4", pin_oe, m_oe);
      chk("R4", pin_out, m_od);
    end
    sweep_pins("R2");
    wr(0, 16'd7, 8'h01); m_oe[7] = 1; m_od[7] = 0;
    chk("R4", {126'b0, pin_oe[7], pin_out[7]}, 128'b10);

    // R5: banked reads of output state
    for (int b = 0; b < NP / 8; b++) begin
      rd(1, 16'h0110 + 16'(b), v); chk("R5", 128'(v), 128'(m_od[b*8 +: 8]));
      rd(0, 16'h0120 + 16'(b), v); chk("R5", 128'(v), 128'(m_oe[b*8 +: 8]));
    end

    // R6: banked writes, coherent in per-pin view
    for (int b = 0; b < NP / 8; b++) begin
      wr(b % NPT, 16'h0110 + 16'(b), 8'((b * 37 + 5) % 256));
      m_od[b*8 +: 8] = 8'((b * 37 + 5) % 256);
      wr((b + 1) % NPT, 16'h0120 + 16'(b), 8'((b * 91 + 66) % 256));
      m_oe[b*8 +: 8] = 8'((b * 91 + 66) % 256);
    end
    sweep_pins("R6");

    // R3: input synchroniser latency
    pin_in[5] = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    addr[0] = 16'd5; #1; chk("R3", 128'(rdata[0][2]), 128'd0);
    @(posedge clk); @(negedge clk); #1;
    chk("R3", 128'(rdata[0][2]), 128'd1);
    for (int i = 0; i < NP; i++) pin_in[i] = ((i * 13 + 7) % 5) < 2;
    repeat (2) @(posedge clk);
    m_in = pin_in;
    for (int b = 0; b < NP / 8; b++) begin
      rd(b % NPT, 16'h0100 + 16'(b), v); chk("R5", 128'(v), 128'(m_in[b*8 +: 8]));
    end
    sweep_pins("R3");

    // R7: ignored writes; R8: unmapped reads
    for (int b = 0; b < 16; b++) wr(b % NPT, 16'h0100 + 16'(b), 8'hFF);
    wr(0, 16'h0080, 8'hFF); wr(1, 16'h0130, 8'hFF); wr(0, 16'h01FF, 8'hFF);
    chk("R7", pin_oe, m_oe);
    chk("R7", pin_out, m_od);
    rd(0, 16'h0080, v); chk("R8", 128'(v), 0);
    rd(1, 16'h0130, v); chk("R8", 128'(v), 0);
    rd(0, 16'h01FF, v); chk("R8", 128'(v), 0);
    rd(1, 16'h2000, v); chk("R8", 128'(v), 0);

    // R9: bank vs per-pin on pin 9 (bank 1 bit 1)
    wr2(16'd9, 8'h03, 16'h0111, 8'h00);
    m_od[15:8] = 8'h00; m_oe[9] = 1;
    chk("R9", {126'b0, pin_oe[9], pin_out[9]}, 128'b10);
    wr2(16'h0121, 8'h00, 16'd9, 8'h03);
    m_oe[15:8] = 8'h00; m_od[9] = 1;
    chk("R9", {126'b0, pin_oe[9], pin_out[9]}, 128'b01);
    sweep_pins("R9");

    // R10: both ports on the same field
    wr2(16'd5, 8'h03, 16'd5, 8'h00);
    m_oe[5] = 0; m_od[5] = 0;
    chk("R10", {126'b0, pin_oe[5], pin_out[5]}, 128'b00);
    wr2(16'h0112, 8'h00, 16'h0112, 8'hA5);
    m_od[23:16] = 8'hA5;
    chk("R10", 128'(pin_out[23:16]), 128'hA5);
    sweep_pins("R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule